// File: doc/BRIEF.md
# Staged Crosspoint Selection Bank

This block holds the routing setup for a 34-output by 34-input single-bit crosspoint. Each output has a host-visible staging register that names the input it should carry. A host writes and reads these registers through a byte-addressed port, using one write strobe and an address. Writes only fill the staging bank. The live routing does not change until a single commit pulse copies every staged selection into the active bank at once.

The active bank drives one combinational select per output. A selection code that names no input turns that output off, and the output then holds 0. Reset puts every register in both banks at the off code. Software can therefore stage a whole new routing map with no glitches and apply it on one clock edge.

Top module: `xpt_cfg_bank`

## Requirements
- R1: When the active selection of output n is a code k below 34, `xpt_out[n]` equals `xpt_in[k]` combinationally.
- R2: A write with `host_wr` high at byte address n (0 to 33) loads the staging register of output n on that clock edge. A data value from 0 to 63 is stored as written. A value above 63 is stored as 63.
- R3: `host_rdata` returns the staged value of the addressed output, zero-extended to 8 bits, for addresses 0 to 33. It returns 0 for any other address.
- R4: A staging write does not change any output. A commit pulse sampled high on a clock edge copies the staging bank into the active bank on that edge.
- R5: All 34 active selections change on the same commit edge, so no partial routing map is ever visible.
- R6: An active code of 34 or more disables its output, which then drives 0 whatever the inputs are.
- R7: Reset (`rst_n` low) sets every staging and active register to 63, so all outputs read 0 and every readback returns 63.
- R8: Writes to addresses 34 and above change no staging register and no output.
- R9: When a write and a commit fall on the same edge, the active bank takes the staging contents from before the write. The written value becomes live only at a later commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| host_addr | input | 8 | Byte address; n selects output n |
| host_wdata | input | 8 | Write data (input index) |
| host_wr | input | 1 | Write strobe |
| host_rdata | output | 8 | Staged value at host_addr |
| commit | input | 1 | Apply staged map to active bank |
| xpt_in | input | 34 | Crosspoint inputs |
| xpt_out | output | 34 | Crosspoint outputs |

## Verification
The assertions check these rules on every cycle:
- a write lands only in its own staging register, and every other staging register holds its value;
- out-of-range addresses read 0 and disturb nothing;
- the active bank matches the previous staging bank after a commit and stays frozen without one;
- a disabled output stays low.

Only the bench scenarios can show the rest. These cover the actual routing values against an independent model, the reset contents, the clamping of large write data, and the ordering when a write meets a commit on the same edge. They also show that outputs stay unchanged through a run of staged writes until the commit.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  // Saturate a host data value to the largest selection code.
  function automatic int unsigned clamp_sel(input int unsigned raw, input int unsigned top);
    return (raw > top) ? top : raw;
  endfunction

  // A selection code routes an input only when it names one.
  function automatic logic sel_live(input int unsigned sel, input int unsigned n_in);
    return sel < n_in;
  endfunction

  // Address decodes to a staging register.
  function automatic logic addr_in_bank(input int unsigned addr, input int unsigned n_out);
    return addr < n_out;
  endfunction

endpackage

// File: rtl/xpt_stage_regs.sv
module xpt_stage_regs
  import xpt_pkg::*;
#(
  parameter int unsigned N_OUT  = 34,
  parameter int unsigned SEL_W  = 6,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [N_OUT-1:0][SEL_W-1:0]  stage_q,
  output logic [DATA_W-1:0]            rdata
);
  localparam int unsigned SEL_OFF = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] wsel;
  logic [N_OUT-1:0] wr_hit;
  logic             addr_ok;

  assign wsel    = SEL_W'(clamp_sel(32'(wdata), SEL_OFF));
  assign addr_ok = addr_in_bank(32'(addr), N_OUT);

  for (genvar i = 0; i < N_OUT; i++) begin : g_stage
    assign wr_hit[i] = wr_en && (addr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)         stage_q[i] <= SEL_W'(SEL_OFF);
      else if (wr_hit[i]) stage_q[i] <= wsel;
    end

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[i] |=> stage_q[i] == SEL_W'(clamp_sel(32'($past(wdata)), SEL_OFF)));

    p_stage_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[i] |=> $stable(stage_q[i]));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_OUT; i++)
      if (addr == ADDR_W'(i)) rdata = DATA_W'(stage_q[i]);
  end

  p_miss_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_ok |-> rdata == '0);

  p_miss_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_ok) |=> $stable(stage_q));

endmodule

// File: rtl/xpt_active_regs.sv
module xpt_active_regs #(
  parameter int unsigned N_OUT = 34,
  parameter int unsigned SEL_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit,
  input  logic [N_OUT-1:0][SEL_W-1:0]  stage_q,
  output logic [N_OUT-1:0][SEL_W-1:0]  act_q
);
  localparam int unsigned SEL_OFF = (1 << SEL_W) - 1;

  logic commit_evt;
  assign commit_evt = commit;

  for (genvar i = 0; i < N_OUT; i++) begin : g_act
    always_ff @(posedge clk) begin
      if (!rst_n)          act_q[i] <= SEL_W'(SEL_OFF);
      else if (commit_evt) act_q[i] <= stage_q[i];
    end
  end

  p_commit_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> act_q == $past(stage_q));

  p_act_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(act_q));

endmodule

// File: rtl/xpt_mux_array.sv
module xpt_mux_array
  import xpt_pkg::*;
#(
  parameter int unsigned N_OUT = 34,
  parameter int unsigned N_IN  = 34,
  parameter int unsigned SEL_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_OUT-1:0][SEL_W-1:0]  act_q,
  input  logic [N_IN-1:0]              din,
  output logic [N_OUT-1:0]             dout
);
  localparam int unsigned PAD = 1 << SEL_W;

  // Unused codes land on constant-zero lanes.
  logic [PAD-1:0] din_pad;
  assign din_pad = {{(PAD-N_IN){1'b0}}, din};

  for (genvar i = 0; i < N_OUT; i++) begin : g_mux
    assign dout[i] = din_pad[act_q[i]];

    p_off_drives_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_live(32'(act_q[i]), N_IN) |-> !dout[i]);
  end

endmodule

// File: rtl/xpt_cfg_bank.sv
module xpt_cfg_bank #(
  parameter int unsigned N_OUT  = 34,
  parameter int unsigned N_IN   = 34,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_wr,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              commit,
  input  logic [N_IN-1:0]   xpt_in,
  output logic [N_OUT-1:0]  xpt_out
);
  localparam int unsigned SEL_W = $clog2(N_IN + 1);

  logic [N_OUT-1:0][SEL_W-1:0] stage_q;
  logic [N_OUT-1:0][SEL_W-1:0] act_q;

  xpt_stage_regs #(.N_OUT(N_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .addr(host_addr),
    .wdata(host_wdata), .stage_q(stage_q), .rdata(host_rdata)
  );

  xpt_active_regs #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_active (
    .clk(clk), .rst_n(rst_n), .commit(commit), .stage_q(stage_q), .act_q(act_q)
  );

  xpt_mux_array #(.N_OUT(N_OUT), .N_IN(N_IN), .SEL_W(SEL_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .act_q(act_q), .din(xpt_in), .dout(xpt_out)
  );

endmodule

// File: tb/xpt_cfg_bank_tb.sv
module xpt_cfg_bank_tb;
  localparam int CLK_P = 10;
  localparam int NO = 34;
  localparam int NI = 34;

  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic host_wr = 0;
  logic [7:0] host_rdata;
  logic commit = 0;
  logic [NI-1:0] xpt_in = '0;
  logic [NO-1:0] xpt_out;

  int checks = 0;
  int fails = 0;
  int stg [NO];
  int act [NO];

  always #(CLK_P/2) clk = ~clk;

  xpt_cfg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rdata(host_rdata), .commit(commit),
    .xpt_in(xpt_in), .xpt_out(xpt_out)
  );

  // address[49:42], data[41:34], input pattern[33:0]
  localparam logic [49:0] VEC [8] = '{
    {8'd0,  8'd5,   34'h0_0000_0020},
    {8'd33, 8'd33,  34'h2_0000_0000},
    {8'd12, 8'd0,   34'h3_FFFF_FFFE},
    {8'd7,  8'd20,  34'h0_0010_0000},
    {8'd20, 8'd34,  34'h3_FFFF_FFFF},
    {8'd1,  8'd200, 34'h3_FFFF_FFFF},
    {8'd30, 8'd17,  34'h0_0002_0000},
    {8'd2,  8'd2,   34'h3_FFFF_FFFB}
  };

  function automatic int sat63(int v);
    if (v > 63) return 63;
    return v;
  endfunction

  function automatic logic route_bit(int sel, logic [NI-1:0] d);
    if (sel >= NI) return 1'b0;
    return d[sel];
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    host_addr = 8'(a); host_wdata = 8'(d); host_wr = 1;
    @(negedge clk);
    host_wr = 0;
    if (a < NO) stg[a] = sat63(d);
  endtask

  task automatic do_commit();
    @(negedge clk);
    commit = 1;
    @(negedge clk);
    commit = 0;
    for (int o = 0; o < NO; o++) act[o] = stg[o];
  endtask

  task automatic wr_commit(int a, int d);
    @(negedge clk);
    host_addr = 8'(a); host_wdata = 8'(d); host_wr = 1; commit = 1;
    @(negedge clk);
    host_wr = 0; commit = 0;
    for (int o = 0; o < NO; o++) act[o] = stg[o];
    if (a < NO) stg[a] = sat63(d);
  endtask

  task automatic check_outs(string req);
    #1;
    for (int o = 0; o < NO; o++)
      check(req, int'(xpt_out[o]), int'(route_bit(act[o], xpt_in)));
  endtask

  task automatic check_reads(string req);
    for (int a = 0; a < NO; a++) begin
      @(negedge clk);
      host_addr = 8'(a);
      #1;
      check(req, int'(host_rdata), stg[a]);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int o = 0; o < NO; o++) begin stg[o] = 63; act[o] = 63; end
    xpt_in = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R7: reset contents
    check_outs("R7");
    check_reads("R7");

    // R1 R2 R6: table walk
    for (int v = 0; v < 8; v++) begin
      wr(int'(VEC[v][49:42]), int'(VEC[v][41:34]));
      do_commit();
      xpt_in = VEC[v][33:0];
      #1;
      check("R1", int'(xpt_out[VEC[v][49:42]]),
            int'(route_bit(sat63(int'(VEC[v][41:34])), VEC[v][33:0])));
    end
    check_reads("R2");

    // R4: staged writes leave outputs alone
    xpt_in = 34'h2_AAAA_5555;
    for (int o = 0; o < NO; o++) wr(o, (o + 7) % NI);
    check_outs("R4");
    check_reads("R3");

    // R5: one commit moves every output together
    @(negedge clk);
    commit = 1;
    @(posedge clk);
    #1;
    commit = 0;
    for (int o = 0; o < NO; o++) act[o] = stg[o];
    check_outs("R5");

    // R3: readback of out-of-bank addresses
    @(negedge clk); host_addr = 8'd34; #1; check("R3", int'(host_rdata), 0);
    @(negedge clk); host_addr = 8'd255; #1; check("R3", int'(host_rdata), 0);

    // R8: out-of-bank writes ignored
    wr(34, 3); wr(200, 9); wr(255, 0);
    do_commit();
    check_outs("R8");
    check_reads("R8");

    // R9: write and commit together
    xpt_in = 34'h0_0000_0001;
    wr(5, 40);
    do_commit();
    wr_commit(5, 0);
    check_outs("R9");
    check("R9", int'(xpt_out[5]), 0);
    do_commit();
    check_outs("R9");
    check("R9", int'(xpt_out[5]), 1);

    // R6: a disabled output holds low under all-ones inputs
    xpt_in = '1;
    wr(9, 63);
    do_commit();
    check_outs("R6");

    // R7: reset again after traffic
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int o = 0; o < NO; o++) begin stg[o] = 63; act[o] = 63; end
    check_outs("R7");
    check_reads("R7");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule